// File: doc/BRIEF.md
# Programmable-Polynomial Parallel CRC Array

This block advances a cyclic redundancy remainder by one whole character in a single step. It is not tied to one generator: the feedback taps come from a polynomial operand supplied with each request. One grid of identical AND/XOR cells therefore serves any generator of degree 16 or less. The grid has one row per character bit and one column per remainder bit. A row-pick assembler takes the result from the row that matches the selected character length of 6, 7 or 8 bits.

The generator is written without its x^16 term, which is implied. A generator of lower degree d is multiplied by x^(16-d), so it sits right-justified in the top bits of the operand, and the remainder then lives in the top d bits. A caller that keeps a remainder for each line hands over the stored remainder, the generator, the character and the length code on a load strobe. Two clock cycles later it collects the new remainder, qualified by a one-cycle valid pulse. The caller writes the remainder back for that line.

On the receive side, the check bits that follow a message are passed through the block in the same way as data. When the message and its check bits arrive intact, the remainder returns to zero.

Top module: `crc_array_unit`

## Requirements
- R1: After reset, `crc_o` is 0 and `vld_o` is 0.
- R2: A load pulse on `ld_i` captures all operands at that clock edge. `vld_o` is high for exactly the single cycle that follows the next edge, and `crc_o` carries the result in that cycle. `vld_o` is low in every other cycle.
- R3: Between results, `crc_o` keeps its last value.
- R4: With `len_i` = 2'b10, the result equals 8 steps of a bit-serial register. The steps take character bits 7 down to 0. Each step sets fb = crc[15] XOR bit, shifts crc left by one and, when fb is 1, XORs in `poly_i`. Bit 16 of the generator is implied.
- R5: With `len_i` = 2'b01, the same rule runs 7 steps over character bits 6 down to 0.
- R6: With `len_i` = 2'b00, the same rule runs 6 steps over character bits 5 down to 0.
- R7: Character bits at or above the selected length have no effect on the result.
- R8: `len_i` = 2'b11 behaves exactly as 2'b10.
- R9: A right-justified generator of degree d below 16, used with a remainder whose low 16-d bits are 0, gives a result whose low 16-d bits are 0. For example, x^6+x^5+1 is given as 16'h8400 and x^8+1 as 16'h0100.
- R10: Suppose a message is followed by its check bits: the top d remainder bits, most significant first, split into characters of the selected length. Then the final remainder is 0.
- R11: A zero remainder and a zero character give a zero result for any generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load strobe; captures the operands |
| poly_i | input | 16 | Generator taps, x^16 implied, right-justified |
| crc_i | input | 16 | Remainder before this character |
| chr_i | input | 8 | Character, right-aligned |
| len_i | input | 2 | Length code: 00 = 6, 01 = 7, 10 or 11 = 8 bits |
| crc_o | output | 16 | Remainder after this character |
| vld_o | output | 1 | One-cycle pulse marking a fresh `crc_o` |

## Verification
The bench builds the block with its default 16-bit remainder and 8-bit character width. At that size the grid holds all three row-pick taps and every column of the remainder. Random generators across the full 16-bit tap space are compared against a bit-serial model for each length code. Directed runs then cover the right-justified low-degree generators, the syndrome round trip at degrees 16, 14 and 12, and the reserved length code.

// File: rtl/crc_arr_pkg.sv
package crc_arr_pkg;

    localparam int CRC_W   = 16;
    localparam int CHR_W   = 8;

    typedef enum logic [1:0] {
        LEN_S  = 2'd0,
        LEN_M  = 2'd1,
        LEN_L  = 2'd2,
        LEN_LX = 2'd3
    } chr_len_e;

    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] rem;
        logic [CHR_W-1:0] chr;
        chr_len_e         len;
    } crc_op_t;

    // Active character bits for a length code, given the widest character.
    function automatic int unsigned len_code_bits(chr_len_e l, int unsigned full);
        case (l)
            LEN_S:   return full - 2;
            LEN_M:   return full - 1;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/crc_chr_align.sv
// Masks the bits above the selected length and moves the character up
// so that its first bit meets the top of the remainder.
module crc_chr_align
    import crc_arr_pkg::*;
#(
    parameter int CHR_W = crc_arr_pkg::CHR_W
) (
    input  logic [CHR_W-1:0] chr_i,
    input  chr_len_e         len_i,
    output logic [CHR_W-1:0] chr_o
);
    int unsigned        nb;
    logic [CHR_W-1:0]   masked;

    always_comb begin
        nb     = len_code_bits(len_i, CHR_W);
        masked = chr_i & ~({CHR_W{1'b1}} << nb);
        chr_o  = masked << (CHR_W - nb);
    end
endmodule

// File: rtl/crc_cell_row.sv
// One row of the grid: each cell passes its diagonal neighbour through,
// flipped when both its tap and the row feedback are set.
module crc_cell_row #(
    parameter int W = crc_arr_pkg::CRC_W
) (
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] poly_i,
    output logic [W-1:0] st_o
);
    logic fb;
    assign fb = st_i[W-1];

    for (genvar m = 0; m < W; m++) begin : g_cell
        logic diag;
        if (m == 0) begin : g_edge
            assign diag = 1'b0;
        end else begin : g_inner
            assign diag = st_i[m-1];
        end
        assign st_o[m] = diag ^ (poly_i[m] & fb);
    end
endmodule

// File: rtl/crc_cell_grid.sv
// Injects the aligned character into the remainder and chains one row per bit.
module crc_cell_grid #(
    parameter int CRC_W = crc_arr_pkg::CRC_W,
    parameter int CHR_W = crc_arr_pkg::CHR_W
) (
    input  logic [CRC_W-1:0]             poly_i,
    input  logic [CRC_W-1:0]             rem_i,
    input  logic [CHR_W-1:0]             chr_i,
    output logic [CHR_W-1:0][CRC_W-1:0]  rows_o
);
    localparam int OFS = CRC_W - CHR_W;

    logic [CRC_W-1:0] seed;
    assign seed = rem_i ^ {chr_i, {OFS{1'b0}}};

    for (genvar r = 0; r < CHR_W; r++) begin : g_row
        if (r == 0) begin : g_first
            crc_cell_row #(.W(CRC_W)) i_row (
                .st_i   (seed),
                .poly_i (poly_i),
                .st_o   (rows_o[r])
            );
        end else begin : g_next
            crc_cell_row #(.W(CRC_W)) i_row (
                .st_i   (rows_o[r-1]),
                .poly_i (poly_i),
                .st_o   (rows_o[r])
            );
        end
    end
endmodule

// File: rtl/crc_row_pick.sv
// AND-OR assembler: gates every row with its select and merges the gated rows.
module crc_row_pick
    import crc_arr_pkg::*;
#(
    parameter int CRC_W = crc_arr_pkg::CRC_W,
    parameter int CHR_W = crc_arr_pkg::CHR_W
) (
    input  logic [CHR_W-1:0][CRC_W-1:0] rows_i,
    input  chr_len_e                    len_i,
    output logic [CRC_W-1:0]            crc_o
);
    logic [CHR_W-1:0]             sel;
    logic [CHR_W-1:0][CRC_W-1:0]  gated;

    always_comb begin
        sel = '0;
        sel[len_code_bits(len_i, CHR_W) - 1] = 1'b1;
    end

    for (genvar r = 0; r < CHR_W; r++) begin : g_gate
        assign gated[r] = rows_i[r] & {CRC_W{sel[r]}};
    end

    always_comb begin
        crc_o = '0;
        for (int r = 0; r < CHR_W; r++) crc_o |= gated[r];
    end
endmodule

// File: rtl/crc_array_unit.sv
module crc_array_unit
    import crc_arr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [CRC_W-1:0]  poly_i,
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [CHR_W-1:0]  chr_i,
    input  logic [1:0]        len_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              vld_o
);
    crc_op_t                     op_q;
    logic                        ld_q;
    logic [CHR_W-1:0]            chr_al;
    logic [CHR_W-1:0][CRC_W-1:0] rows;
    logic [CRC_W-1:0]            picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            ld_q <= 1'b0;
        end else begin
            ld_q <= ld_i;
            if (ld_i) begin
                op_q.poly <= poly_i;
                op_q.rem  <= crc_i;
                op_q.chr  <= chr_i;
                op_q.len  <= chr_len_e'(len_i);
            end
        end
    end

    crc_chr_align #(.CHR_W(CHR_W)) i_align (
        .chr_i (op_q.chr),
        .len_i (op_q.len),
        .chr_o (chr_al)
    );

    crc_cell_grid #(.CRC_W(CRC_W), .CHR_W(CHR_W)) i_grid (
        .poly_i (op_q.poly),
        .rem_i  (op_q.rem),
        .chr_i  (chr_al),
        .rows_o (rows)
    );

    crc_row_pick #(.CRC_W(CRC_W), .CHR_W(CHR_W)) i_pick (
        .rows_i (rows),
        .len_i  (op_q.len),
        .crc_o  (picked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= ld_q;
            if (ld_q) crc_o <= picked;
        end
    end

    p_vld_after_ld_r2: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> ##1 vld_o);
    p_vld_only_ld_r2: assert property (@(posedge clk) disable iff (rst)
        !ld_i |=> ##1 !vld_o);
    p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
        !ld_q |=> $stable(crc_o));
    p_zero_in_zero_out_r11: assert property (@(posedge clk) disable iff (rst)
        (ld_i && crc_i == '0 && chr_i == '0) |=> ##1 (crc_o == '0));

endmodule

// File: tb/test_crc_array_unit.sv
`timescale 1ns/1ps
module test_crc_array_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_i;
    logic [15:0] poly_i, crc_i;
    logic [7:0]  chr_i;
    logic [1:0]  len_i;
    logic [15:0] crc_o;
    logic        vld_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    crc_array_unit i_crc_array_unit (
        .clk(clk), .rst(rst), .ld_i(ld_i), .poly_i(poly_i), .crc_i(crc_i),
        .chr_i(chr_i), .len_i(len_i), .crc_o(crc_o), .vld_o(vld_o)
    );

    function automatic logic [15:0] ref_step(logic [15:0] poly, logic [15:0] rem,
                                             logic [7:0] ch, logic [1:0] lc);
        int n;
        logic [15:0] s;
        logic fb;
        n = (lc == 2'd0) ? 6 : (lc == 2'd1) ? 7 : 8;
        s = rem;
        for (int i = n - 1; i >= 0; i--) begin
            fb = s[15] ^ ch[i];
            s  = {s[14:0], 1'b0};
            if (fb) s = s ^ poly;
        end
        return s;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [15:0] poly, input logic [15:0] rem,
                       input logic [7:0] ch, input logic [1:0] lc,
                       input string tag, output logic [15:0] got);
        logic [15:0] held;
        @(negedge clk);
        poly_i = poly; crc_i = rem; chr_i = ch; len_i = lc; ld_i = 1'b1;
        @(negedge clk);
        ld_i = 1'b0;
        poly_i = $urandom; crc_i = $urandom; chr_i = $urandom;
        check("R2 vld low before result", {15'd0, vld_o}, 16'd0);
        @(negedge clk);
        check("R2 vld pulse", {15'd0, vld_o}, 16'd1);
        check(tag, crc_o, ref_step(poly, rem, ch, lc));
        got  = crc_o;
        held = crc_o;
        @(negedge clk);
        check("R2 vld drops", {15'd0, vld_o}, 16'd0);
        check("R3 hold", crc_o, held);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] r, a, b;
        rst = 1'b1; ld_i = 1'b0; poly_i = '0; crc_i = '0; chr_i = '0; len_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 crc reset", crc_o, 16'd0);
        check("R1 vld reset", {15'd0, vld_o}, 16'd0);

        // R4 directed and random, 8-bit
        run(16'h8005, 16'h0000, 8'h31, 2'b10, "R4 crc16 0x31", r);
        run(16'h1021, 16'hFFFF, 8'hA5, 2'b10, "R4 ccitt", r);
        for (int i = 0; i < 40; i++) run($urandom, $urandom, $urandom, 2'b10, "R4 random", r);
        // R5 / R6 random, full char bits random
        for (int i = 0; i < 40; i++) run($urandom, $urandom, $urandom, 2'b01, "R5 random", r);
        for (int i = 0; i < 40; i++) run($urandom, $urandom, $urandom, 2'b00, "R6 random", r);
        // R8 reserved code
        for (int i = 0; i < 20; i++) run($urandom, $urandom, $urandom, 2'b11, "R8 code 11", r);

        // R7 high bits ignored
        run(16'h8084, 16'h3C3C, 8'h15, 2'b00, "R7 base 6", a);
        run(16'h8084, 16'h3C3C, 8'hD5, 2'b00, "R7 high set 6", b);
        check("R7 6-bit high bits", b, a);
        run(16'h8084, 16'h1234, 8'h2A, 2'b01, "R7 base 7", a);
        run(16'h8084, 16'h1234, 8'hAA, 2'b01, "R7 high set 7", b);
        check("R7 7-bit high bit", b, a);

        // R9 right-justified low degree
        run(16'h8400, 16'hFC00, 8'h2D, 2'b00, "R9 x6+x5+1", r);
        check("R9 low ten zero", r & 16'h03FF, 16'd0);
        run(16'h0100, 16'h5A00, 8'hC3, 2'b10, "R9 x8+1", r);
        check("R9 low eight zero", r & 16'h00FF, 16'd0);

        // R10 syndrome, degree 16 with 8-bit chars
        r = 16'h0000;
        for (int i = 0; i < 4; i++) run(16'h8005, r, $urandom, 2'b10, "R10 msg8", r);
        a = r;
        run(16'h8005, r, a[15:8], 2'b10, "R10 chk8 hi", r);
        run(16'h8005, r, a[7:0], 2'b10, "R10 chk8 lo", r);
        check("R10 syndrome deg16", r, 16'd0);
        // degree 14 with 7-bit chars
        r = 16'h0000;
        for (int i = 0; i < 3; i++) run(16'h8084, r, $urandom, 2'b01, "R10 msg7", r);
        a = r;
        run(16'h8084, r, {1'b0, a[15:9]}, 2'b01, "R10 chk7 hi", r);
        run(16'h8084, r, {1'b0, a[8:2]}, 2'b01, "R10 chk7 lo", r);
        check("R10 syndrome deg14", r, 16'd0);
        // degree 12 with 6-bit chars
        r = 16'h0000;
        for (int i = 0; i < 3; i++) run(16'h80F0, r, $urandom, 2'b00, "R10 msg6", r);
        a = r;
        run(16'h80F0, r, {2'b00, a[15:10]}, 2'b00, "R10 chk6 hi", r);
        run(16'h80F0, r, {2'b00, a[9:4]}, 2'b00, "R10 chk6 lo", r);
        check("R10 syndrome deg12", r, 16'd0);

        // R11 zero operands
        run(16'hFFFF, 16'h0000, 8'h00, 2'b10, "R11 zero 8", r);
        check("R11 zero result", r, 16'd0);
        run(16'hBEEF, 16'h0000, 8'h00, 2'b00, "R11 zero 6", r);
        check("R11 zero result 6", r, 16'd0);

        summary();
    end
endmodule